// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the data side of a 32-bit processor that spreads each instruction over several clock cycles. One memory port serves both instruction fetch and data access, and an address-select input picks which of the two is presented in a given cycle. Partial results are held between cycles in a small set of registers:

- a program counter;
- an instruction register;
- a memory data register;
- two operand registers;
- an ALU result register.

The datapath also contains a 32-entry register file, an ALU that produces a zero flag, and the multiplexers that steer operands and results.

An external controller drives every select and write-enable one cycle at a time. The datapath returns the opcode field and the zero flag to that controller. The memory sits outside the block: it sees the address, the write data and the two access strobes, and it returns read data combinationally within the cycle.

Top module: `mc_datapath`

## Requirements
- R1: An asynchronous active-low reset sets the program counter to parameter RESET_PC. It clears the instruction register, the operand registers, the memory data register, the ALU result register and all 32 registers of the register file.
- R2: `mem_addr` shows the program counter when `ctl_addr_sel`=0, and the ALU result register when `ctl_addr_sel`=1.
- R3: The instruction register loads `mem_rdata` at a clock edge only when `ctl_ir_load`=1; otherwise it holds its value. `opcode` is bits 31:26 of the instruction register.
- R4: ALU operand A is the program counter when `ctl_a_sel`=0, and the first operand register when `ctl_a_sel`=1. Operand B depends on `ctl_b_sel`:
  - 00: the second operand register;
  - 01: the constant 4;
  - 10: instruction bits 15:0 sign-extended;
  - 11: that sign-extended value shifted left by 2.
- R5: The ALU function depends on `ctl_alu_mode`:
  - 00 and 11: add;
  - 01: subtract (A minus B);
  - 10: decode the function field, instruction bits 5:0, as follows: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 signed set-less-than (result 1 or 0). Any other function code gives 0.
- R6: `alu_zero` is 1 exactly when the current ALU result is zero.
- R7: The program counter loads at a clock edge when `ctl_pc_we`=1, or when `ctl_pc_we_zero`=1 and `alu_zero`=1. Otherwise it holds its value.
- R8: The next program counter depends on `ctl_pc_src`:
  - 00: the current ALU result;
  - 01: the ALU result register;
  - 10: program counter bits 31:28 joined with instruction bits 25:0 and two zero bits;
  - 11: the unchanged program counter.
- R9: On every clock edge the operand registers capture the register-file entries addressed by instruction bits 25:21 (first operand) and 20:16 (second operand). `mem_wdata` is always the second operand register.
- R10: With `ctl_rf_we`=1, the register file writes at the clock edge.
  - Destination: instruction bits 15:11 when `ctl_rd_sel`=1, bits 20:16 when it is 0.
  - Data: the memory data register when `ctl_wb_from_mem`=1, the ALU result register when it is 0.
  - Register 0 always reads as zero, and writes to it are discarded.
- R11: The memory data register captures `mem_rdata`, and the ALU result register captures the ALU result, on every clock edge.
- R12: `mem_rd_en` follows `ctl_mem_rd` and `mem_wr_en` follows `ctl_mem_wr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_addr_sel | input | 1 | Memory address source: 0 program counter, 1 ALU result register |
| ctl_mem_rd | input | 1 | Memory read strobe from the controller |
| ctl_mem_wr | input | 1 | Memory write strobe from the controller |
| ctl_ir_load | input | 1 | Instruction register load enable |
| ctl_wb_from_mem | input | 1 | Register write data source: 1 memory data register, 0 ALU result register |
| ctl_pc_src | input | 2 | Next program counter source |
| ctl_alu_mode | input | 2 | ALU mode: add, subtract or function-field decode |
| ctl_a_sel | input | 1 | ALU operand A source |
| ctl_b_sel | input | 2 | ALU operand B source |
| ctl_rf_we | input | 1 | Register file write enable |
| ctl_rd_sel | input | 1 | Write destination: 1 instruction bits 15:11, 0 bits 20:16 |
| ctl_pc_we | input | 1 | Unconditional program counter load |
| ctl_pc_we_zero | input | 1 | Program counter load qualified by the zero flag |
| mem_rdata | input | 32 | Read data from memory |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| opcode | output | 6 | Instruction bits 31:26 |
| alu_zero | output | 1 | ALU result is zero |

## Verification
The bench builds the block with RESET_PC = 32'h3000_0000 instead of the default zero. With that value, every jump must carry a non-zero upper nibble into its target, so a target formed from the wrong program counter bits shows up at the next fetch address. It also places code at an address whose low bits still index the bench's small memory from entry 0. Random instruction streams run from that base and use random jump fields, branch offsets, register numbers (including register 0) and function codes (including an undefined one).

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_addr_sel,
  input  logic        ctl_mem_rd,
  input  logic        ctl_mem_wr,
  input  logic        ctl_ir_load,
  input  logic        ctl_wb_from_mem,
  input  logic [1:0]  ctl_pc_src,
  input  logic [1:0]  ctl_alu_mode,
  input  logic        ctl_a_sel,
  input  logic [1:0]  ctl_b_sel,
  input  logic        ctl_rf_we,
  input  logic        ctl_rd_sel,
  input  logic        ctl_pc_we,
  input  logic        ctl_pc_we_zero,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_rd_en,
  output logic        mem_wr_en,
  output logic [5:0]  opcode,
  output logic        alu_zero
);

  localparam int NREG = 32;
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  logic [31:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [31:0] rf [NREG];

  logic [4:0]  rs_idx, rt_idx, rd_idx, wb_idx;
  logic [31:0] imm_ext, rd_a, rd_b, wb_data;
  logic [31:0] alu_a, alu_b, alu_res, pc_next;
  logic        pc_load;

  assign rs_idx  = ir_q[25:21];
  assign rt_idx  = ir_q[20:16];
  assign rd_idx  = ir_q[15:11];
  assign imm_ext = {{16{ir_q[15]}}, ir_q[15:0]};

  assign rd_a = (rs_idx == 5'd0) ? 32'd0 : rf[rs_idx];
  assign rd_b = (rt_idx == 5'd0) ? 32'd0 : rf[rt_idx];

  assign alu_a = ctl_a_sel ? a_q : pc_q;

  always_comb begin
    case (ctl_b_sel)
      2'b00:   alu_b = b_q;
      2'b01:   alu_b = 32'd4;
      2'b10:   alu_b = imm_ext;
      default: alu_b = {imm_ext[29:0], 2'b00};
    endcase
  end

  always_comb begin
    case (ctl_alu_mode)
      2'b01: alu_res = alu_a - alu_b;
      2'b10: begin
        case (ir_q[5:0])
          FN_ADD:  alu_res = alu_a + alu_b;
          FN_SUB:  alu_res = alu_a - alu_b;
          FN_AND:  alu_res = alu_a & alu_b;
          FN_OR:   alu_res = alu_a | alu_b;
          FN_SLT:  alu_res = {31'd0, $signed(alu_a) < $signed(alu_b)};
          default: alu_res = 32'd0;
        endcase
      end
      default: alu_res = alu_a + alu_b;
    endcase
  end

  assign alu_zero = (alu_res == 32'd0);

  always_comb begin
    case (ctl_pc_src)
      2'b00:   pc_next = alu_res;
      2'b01:   pc_next = aluout_q;
      2'b10:   pc_next = {pc_q[31:28], ir_q[25:0], 2'b00};
      default: pc_next = pc_q;
    endcase
  end

  assign pc_load = ctl_pc_we | (ctl_pc_we_zero & alu_zero);
  assign wb_idx  = ctl_rd_sel ? rd_idx : rt_idx;
  assign wb_data = ctl_wb_from_mem ? mdr_q : aluout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      mdr_q    <= mem_rdata;
      a_q      <= rd_a;
      b_q      <= rd_b;
      aluout_q <= alu_res;
      if (pc_load) pc_q <= pc_next;
      if (ctl_ir_load) ir_q <= mem_rdata;
      if (ctl_rf_we && wb_idx != 5'd0) rf[wb_idx] <= wb_data;
    end
  end

  assign mem_addr  = ctl_addr_sel ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_rd_en = ctl_mem_rd;
  assign mem_wr_en = ctl_mem_wr;
  assign opcode    = ir_q[31:26];

endmodule

// File: rtl/mc_datapath_sva.sv
module mc_datapath_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_ir_load,
  input logic        ctl_pc_we,
  input logic        ctl_pc_we_zero,
  input logic [1:0]  ctl_pc_src,
  input logic        alu_zero,
  input logic [31:0] mem_rdata,
  input logic [31:0] pc_q,
  input logic [31:0] ir_q,
  input logic [31:0] mdr_q,
  input logic [31:0] aluout_q,
  input logic [31:0] alu_res
);

  a_r3_ir_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ir_load |=> $stable(ir_q));

  a_r3_ir_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ir_load |=> ir_q == $past(mem_rdata));

  a_r7_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_pc_we && !(ctl_pc_we_zero && alu_zero)) |=> $stable(pc_q));

  a_r8_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_pc_we && ctl_pc_src == 2'b10) |=>
      (pc_q[31:28] == $past(pc_q[31:28]) && pc_q[27:0] == {$past(ir_q[25:0]), 2'b00}));

  a_r11_mdr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mdr_q == $past(mem_rdata));

  a_r11_aluout_capture: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> aluout_q == $past(alu_res));

endmodule

bind mc_datapath mc_datapath_sva u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctl_ir_load    (ctl_ir_load),
  .ctl_pc_we      (ctl_pc_we),
  .ctl_pc_we_zero (ctl_pc_we_zero),
  .ctl_pc_src     (ctl_pc_src),
  .alu_zero       (alu_zero),
  .mem_rdata      (mem_rdata),
  .pc_q           (pc_q),
  .ir_q           (ir_q),
  .mdr_q          (mdr_q),
  .aluout_q       (aluout_q),
  .alu_res        (alu_res)
);

// File: tb/test_mc_datapath.sv
`timescale 1ns/1ps
module test_mc_datapath;
  localparam logic [31:0] BASE = 32'h3000_0000;
  localparam int NINSTR = 1500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_addr_sel, c_rd, c_wr, c_ir, c_wbm, c_a_sel, c_rf_we, c_rd_sel, c_pc_we, c_pc_wz;
  logic [1:0] c_pc_src, c_mode, c_b_sel;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic mem_rd_en, mem_wr_en, alu_zero;
  logic [5:0] opcode;

  logic [31:0] mem [256];
  logic [31:0] ref_rf [32];
  logic [31:0] ref_pc;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mc_datapath #(.RESET_PC(BASE)) i_mc_datapath (
    .clk(clk), .rst_n(rst_n), .ctl_addr_sel(c_addr_sel), .ctl_mem_rd(c_rd),
    .ctl_mem_wr(c_wr), .ctl_ir_load(c_ir), .ctl_wb_from_mem(c_wbm),
    .ctl_pc_src(c_pc_src), .ctl_alu_mode(c_mode), .ctl_a_sel(c_a_sel),
    .ctl_b_sel(c_b_sel), .ctl_rf_we(c_rf_we), .ctl_rd_sel(c_rd_sel),
    .ctl_pc_we(c_pc_we), .ctl_pc_we_zero(c_pc_wz), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .opcode(opcode), .alu_zero(alu_zero));

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_wr_en) mem[mem_addr[9:2]] <= mem_wdata;

  task automatic clr();
    c_addr_sel = 0; c_rd = 0; c_wr = 0; c_ir = 0; c_wbm = 0; c_a_sel = 0;
    c_rf_we = 0; c_rd_sel = 0; c_pc_we = 0; c_pc_wz = 0;
    c_pc_src = 2'b00; c_mode = 2'b00; c_b_sel = 2'b00;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] fn_ref(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'b100000: return a + b;
      6'b100010: return a - b;
      6'b100100: return a & b;
      6'b100101: return a | b;
      6'b101010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default:   return 32'd0;
    endcase
  endfunction

  task automatic run_instr(input logic [31:0] ins, input bit probe);
    logic [5:0] op;
    logic [4:0] rs, rt, rd;
    logic [31:0] br_tgt, res, ea, val;
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    mem[ref_pc[9:2]] = ins;
    // fetch
    clr(); c_pc_we = 1; c_ir = 1; c_rd = 1; c_b_sel = 2'b01;
    #1;
    check("R2/R8 fetch address", mem_addr, ref_pc);
    check("R12 read strobe", {31'd0, mem_rd_en}, 32'd1);
    tick();
    ref_pc = ref_pc + 32'd4;
    check("R3 opcode", {26'd0, opcode}, {26'd0, op});
    check("R4/R7 pc plus 4", mem_addr, ref_pc);
    if (probe) begin
      mem[ref_pc[9:2]] = ~ins;
      clr();
      tick();
      check("R3 ir holds", {26'd0, opcode}, {26'd0, op});
      check("R7 pc holds", mem_addr, ref_pc);
      clr(); c_pc_we = 1; c_pc_src = 2'b11;
      tick();
      check("R8 source 11 keeps pc", mem_addr, ref_pc);
    end
    // decode
    clr(); c_b_sel = 2'b11;
    tick();
    check("R9/R10 second operand", mem_wdata, ref_rf[rt]);
    br_tgt = ref_pc + {sext(ins[15:0])[29:0], 2'b00};
    case (op)
      6'b000000: begin
        clr(); c_a_sel = 1; c_mode = 2'b10;
        #1;
        res = fn_ref(ins[5:0], ref_rf[rs], ref_rf[rt]);
        check("R6 zero flag function op", {31'd0, alu_zero}, {31'd0, res == 32'd0});
        tick();
        clr(); c_addr_sel = 1; c_rf_we = 1; c_rd_sel = 1;
        #1;
        check("R5/R11 function result", mem_addr, res);
        tick();
        if (rd != 5'd0) ref_rf[rd] = res;
      end
      6'b100011, 6'b101011: begin
        clr(); c_a_sel = 1; c_b_sel = 2'b10;
        tick();
        ea = ref_rf[rs] + sext(ins[15:0]);
        clr(); c_addr_sel = 1;
        if (op == 6'b100011) c_rd = 1; else c_wr = 1;
        #1;
        check("R2/R4 data address", mem_addr, ea);
        if (op == 6'b101011) begin
          check("R9 store data", mem_wdata, ref_rf[rt]);
          check("R12 write strobe", {31'd0, mem_wr_en}, 32'd1);
        end
        val = mem[ea[9:2]];
        tick();
        if (op == 6'b100011) begin
          clr(); c_rf_we = 1; c_wbm = 1;
          tick();
          if (rt != 5'd0) ref_rf[rt] = val;
        end
      end
      6'b000100: begin
        clr(); c_a_sel = 1; c_mode = 2'b01; c_pc_src = 2'b01; c_pc_wz = 1;
        #1;
        check("R6 zero flag compare", {31'd0, alu_zero}, {31'd0, ref_rf[rs] == ref_rf[rt]});
        tick();
        if (ref_rf[rs] == ref_rf[rt]) ref_pc = br_tgt;
      end
      default: begin
        clr(); c_pc_we = 1; c_pc_src = 2'b10;
        tick();
        ref_pc = {ref_pc[31:28], ins[25:0], 2'b00};
      end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [5:0] fns [6];
    fns[0] = 6'b100000; fns[1] = 6'b100010; fns[2] = 6'b100100;
    fns[3] = 6'b100101; fns[4] = 6'b101010; fns[5] = 6'b000111;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    for (int i = 0; i < 32; i++) ref_rf[i] = 32'd0;
    ref_pc = BASE;
    clr();
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset pc", mem_addr, BASE);
    check("R1 reset opcode", {26'd0, opcode}, 32'd0);
    check("R1 reset operand", mem_wdata, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run_instr({6'b000010, 26'h0AB_CDE1}, 1'b1);
    run_instr({6'b100011, 5'd0, 5'd0, 16'h0000}, 1'b0);
    run_instr({6'b000000, 5'd3, 5'd0, 5'd0, 5'd0, 6'b100000}, 1'b0);
    for (int n = 0; n < NINSTR; n++) begin
      int kind;
      logic [4:0] rs, rt, rd;
      logic [31:0] ins;
      kind = $urandom_range(0, 9);
      rs = 5'($urandom); rt = 5'($urandom); rd = 5'($urandom);
      if (kind < 4)
        ins = {6'b000000, rs, rt, rd, 5'd0, fns[$urandom_range(0, 5)]};
      else if (kind < 6)
        ins = {6'b100011, rs, rt, 16'($urandom)};
      else if (kind == 6)
        ins = {6'b101011, rs, rt, 16'($urandom)};
      else if (kind < 9)
        ins = {6'b000100, rs, ($urandom_range(0, 1) == 1) ? rs : rt, 16'($signed($urandom_range(0, 127)) - 16'sd64)};
      else
        ins = {6'b000010, 26'($urandom)};
      run_instr(ins, (n % 97) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule